// File: doc/BRIEF.md
# Page-Mode DRAM Supercell Controller

This block serves single-supercell reads and writes from a processor-side request port. It does so by driving a small behavioural DRAM core that holds a 4 x 4 array of 8-bit supercells. The core is reached through a narrow multiplexed address bus: the row index goes out under a row strobe, and the column index follows under a column strobe. A row strobe copies the whole addressed row into an internal row buffer. A column strobe then either moves one supercell from that buffer onto the data lines or updates it in place. The buffer is written back to the array when the row is closed.

The controller leaves the last row open. A later access to the same row therefore needs only a column phase, while an access to another row first closes the open row and then opens the new one. A free-running refresh timer raises a refresh request every `REF_PERIOD` cycles. The controller serves that request only between transactions. Each refresh closes any open row and then restores one row, stepping through the rows in a fixed rotation.

The requester issues a one-cycle `req_i` while `busy_o` is low. It then waits for the one-cycle `done_o`. In that cycle, `rdata_o` carries the data of a read.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ras_o` and `cas_o` are low, no row is open and every supercell reads as 0.
- R2: Address bits [3:2] select the row and bits [1:0] select the column. A read returns the value most recently written to the same address.
- R3: An access to the row that is already open takes only a column phase: `done_o` rises `T_CL` clock edges after the accepting edge.
- R4: An access made while no row is open takes `T_RCD + T_CL` edges, made up of one row phase followed by one column phase.
- R5: An access to a row other than the open one takes `T_RP + T_RCD + T_CL` edges. The close step writes the buffer back, so no earlier write is lost.
- R6: `done_o` is high for exactly one cycle per accepted request, right after a column phase. For a read, `rdata_o` is valid in that cycle.
- R7: A run of accesses within one row produces a single row-strobe activation. The number of row-strobe rising edges equals the number of row openings, counting both request row openings and refresh row openings.
- R8: `busy_o` is high while a transaction or refresh is under way or a refresh is waiting. A `req_i` seen while `busy_o` is high is ignored and changes no stored data.
- R9: A refresh request arises every `REF_PERIOD` cycles and stays pending until served. It is served only when the controller is idle, before any new request. It lasts `T_RCD` edges, plus `T_RP` edges when a row is open, and it leaves no row open.
- R10: Refreshes visit rows 0, 1, 2, 3, 0, ... in turn, and they preserve all stored data.
- R11: `ras_o` and `cas_o` are never high together. `maddr_o` carries the row index while `ras_o` is high and the column index while `cas_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, taken when `busy_o` is low |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ROW_W+COL_W | Supercell address: row in the upper bits, column in the lower bits |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid while `done_o` is high after a read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Controller cannot take a request this cycle |
| ras_o | output | 1 | Row strobe toward the core |
| cas_o | output | 1 | Column strobe toward the core |
| maddr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address bus |

## Verification
The assertions assume that `req_i` is sampled only on clock edges and that a request is meaningful only when `busy_o` is low. They also assume that the requester holds nothing across cycles, so the controller's captured operation must not move while it is busy. The stimulus waits for `busy_o` to fall before each request and pulses `req_i` for one cycle. The one exception is a deliberate request injected during a busy window, which checks that such a request is dropped. The bench runs long idle gaps so that refresh requests land both between requests and during transactions.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ROW    = 3'd1,
    ST_COL    = 3'd2,
    ST_CLOSE  = 3'd3,
    ST_RCLOSE = 3'd4,
    ST_RROW   = 3'd5
  } pmd_state_e;

  // last cycle of a phase that lasts len cycles
  function automatic logic phase_last(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pmd_refresh_timer.sv
module pmd_refresh_timer #(
  parameter int unsigned REF_PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  output logic pending_o
);
  localparam int unsigned TW = $clog2(REF_PERIOD + 1);

  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = (tcnt == TW'(REF_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt      <= '0;
      pending_o <= 1'b0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick)        pending_o <= 1'b1;
      else if (take_i) pending_o <= 1'b0;
    end
  end

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !take_i) |=> pending_o);

endmodule

// File: rtl/pmd_dram_core.sv
module pmd_dram_core #(
  parameter int unsigned ROW_W  = 2,
  parameter int unsigned COL_W  = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wb_i,
  input  logic [MA_W-1:0]   maddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dq_o
);
  localparam int unsigned ROWS = 1 << ROW_W;
  localparam int unsigned COLS = 1 << COL_W;

  logic [DATA_W-1:0] cells [ROWS][COLS];
  logic [DATA_W-1:0] rbuf  [COLS];
  logic              loaded;
  logic [ROW_W-1:0]  ra;
  logic [COL_W-1:0]  ca;

  assign ra = maddr_i[ROW_W-1:0];
  assign ca = maddr_i[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cells[r][c] <= '0;
      for (int c = 0; c < COLS; c++) rbuf[c] <= '0;
      dq_o   <= '0;
      loaded <= 1'b0;
    end else begin
      if (act_i) begin
        for (int c = 0; c < COLS; c++) rbuf[c] <= cells[ra][c];
        loaded <= 1'b1;
      end
      if (wb_i && !act_i)
        for (int c = 0; c < COLS; c++) cells[ra][c] <= rbuf[c];
      if (rd_i) dq_o <= rbuf[ca];
      if (wr_i) rbuf[ca] <= wdata_i;
    end
  end

  // R7
  col_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i || wr_i) |-> loaded);

  // R11
  col_no_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i || wr_i) |-> !act_i);

endmodule

// File: rtl/pmd_ctrl_fsm.sv
module pmd_ctrl_fsm
  import pmd_pkg::*;
#(
  parameter int unsigned ROW_W  = 2,
  parameter int unsigned COL_W  = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MA_W   = 2,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CL   = 2,
  parameter int unsigned T_RP   = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   ref_pend_i,
  output logic                   ref_take_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   ras_o,
  output logic                   cas_o,
  output logic [MA_W-1:0]        maddr_o,
  output logic                   act_o,
  output logic                   rd_o,
  output logic                   wr_o,
  output logic                   wb_o,
  output logic [DATA_W-1:0]      wdata_o
);
  localparam int unsigned MAXT = max3(T_RCD, T_CL, T_RP);
  localparam int unsigned CW   = $clog2(MAXT + 1) + 1;
  localparam int unsigned AW   = ROW_W + COL_W;

  function automatic logic [ROW_W-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [AW-1:0] a);
    return a[COL_W-1:0];
  endfunction

  pmd_state_e        state, state_n;
  logic [CW-1:0]     cnt;
  logic              op_we;
  logic [ROW_W-1:0]  op_row;
  logic [COL_W-1:0]  op_col;
  logic [DATA_W-1:0] op_data;
  logic              open_vld;
  logic [ROW_W-1:0]  open_row;
  logic [ROW_W-1:0]  ref_row;
  logic              accept;
  logic              last;
  logic              same_row;

  assign busy_o     = (state != ST_IDLE) || ref_pend_i;
  assign accept     = (state == ST_IDLE) && !ref_pend_i && req_i;
  assign ref_take_o = (state == ST_IDLE) && ref_pend_i;
  assign same_row   = open_vld && (row_of(addr_i) == open_row);

  always_comb begin
    unique case (state)
      ST_ROW, ST_RROW:    last = phase_last(32'(cnt), T_RCD);
      ST_COL:             last = phase_last(32'(cnt), T_CL);
      ST_CLOSE, ST_RCLOSE: last = phase_last(32'(cnt), T_RP);
      default:            last = 1'b0;
    endcase
  end

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: begin
        if (ref_take_o)  state_n = open_vld ? ST_RCLOSE : ST_RROW;
        else if (accept) state_n = same_row ? ST_COL : (open_vld ? ST_CLOSE : ST_ROW);
      end
      ST_CLOSE:  if (last) state_n = ST_ROW;
      ST_ROW:    if (last) state_n = ST_COL;
      ST_COL:    if (last) state_n = ST_IDLE;
      ST_RCLOSE: if (last) state_n = ST_RROW;
      ST_RROW:   if (last) state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  // strobes, bus and core events
  always_comb begin
    ras_o   = (state == ST_ROW) || (state == ST_RROW);
    cas_o   = (state == ST_COL);
    maddr_o = '0;
    unique case (state)
      ST_ROW:              maddr_o = MA_W'(op_row);
      ST_RROW:             maddr_o = MA_W'(ref_row);
      ST_COL:              maddr_o = MA_W'(op_col);
      ST_CLOSE, ST_RCLOSE: maddr_o = MA_W'(open_row);
      default:             maddr_o = '0;
    endcase
    act_o   = ras_o && (cnt == '0);
    rd_o    = cas_o && (cnt == '0) && !op_we;
    wr_o    = cas_o && (cnt == '0) && op_we;
    wb_o    = last && ((state == ST_CLOSE) || (state == ST_RCLOSE) || (state == ST_RROW));
    wdata_o = op_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      op_we    <= 1'b0;
      op_row   <= '0;
      op_col   <= '0;
      op_data  <= '0;
      open_vld <= 1'b0;
      open_row <= '0;
      ref_row  <= '0;
      done_o   <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= (state_n != state) ? '0 : cnt + 1'b1;
      done_o <= (state == ST_COL) && last;
      if (accept) begin
        op_we   <= we_i;
        op_row  <= row_of(addr_i);
        op_col  <= col_of(addr_i);
        op_data <= wdata_i;
      end
      if ((state == ST_CLOSE || state == ST_RCLOSE) && last) open_vld <= 1'b0;
      if (state == ST_ROW && last) begin
        open_vld <= 1'b1;
        open_row <= op_row;
      end
      if (state == ST_RROW && last) ref_row <= ref_row + 1'b1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(cas_o));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_o && cas_o));

  // R8
  ignore_busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && busy_o) |=> ($stable(op_row) && $stable(op_col) && $stable(op_we)
                           && $stable(op_data)));

  // R9
  refresh_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_take_o && req_i) |=> !cas_o);

endmodule

// File: rtl/pagemode_dram_ctrl.sv
module pagemode_dram_ctrl #(
  parameter int unsigned ROW_W      = 2,
  parameter int unsigned COL_W      = 2,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned T_RCD      = 2,
  parameter int unsigned T_CL       = 2,
  parameter int unsigned T_RP       = 1,
  parameter int unsigned REF_PERIOD = 64,
  localparam int unsigned MA_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   done_o,
  output logic                   busy_o,
  output logic                   ras_o,
  output logic                   cas_o,
  output logic [MA_W-1:0]        maddr_o
);
  logic              ref_pend, ref_take;
  logic              act, rd, wr, wb;
  logic [DATA_W-1:0] core_wdata;

  pmd_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .take_i(ref_take), .pending_o(ref_pend)
  );

  pmd_ctrl_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .MA_W(MA_W),
    .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ref_pend_i(ref_pend), .ref_take_o(ref_take),
    .busy_o(busy_o), .done_o(done_o), .ras_o(ras_o), .cas_o(cas_o),
    .maddr_o(maddr_o), .act_o(act), .rd_o(rd), .wr_o(wr), .wb_o(wb),
    .wdata_o(core_wdata)
  );

  pmd_dram_core #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .MA_W(MA_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .act_i(act), .rd_i(rd), .wr_i(wr), .wb_i(wb),
    .maddr_i(maddr_o), .wdata_i(core_wdata), .dq_o(rdata_o)
  );

endmodule

// File: tb/pagemode_dram_ctrl_bench.sv
module pagemode_dram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_CL = 3, T_RP = 2, REF = 37;
  localparam int WATCHDOG = 20000;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic done, busy, ras, cas;
  logic [1:0] maddr;

  int checks = 0, errors = 0, cycles = 0;

  pagemode_dram_ctrl #(.T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .REF_PERIOD(REF))
    u_pagemode_dram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .busy_o(busy),
      .ras_o(ras), .cas_o(cas), .maddr_o(maddr));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int mem [16];
  int m_tcnt, m_left, m_rptr, m_orow, m_rasrow, m_curcol, m_exp, m_lat, m_kind, m_acts;
  bit m_pend, m_valid, m_done, m_cpu, m_we;

  always @(posedge clk) begin
    bit tick;
    int r, lat;
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 0;
      m_tcnt = 0; m_left = 0; m_rptr = 0; m_orow = 0; m_rasrow = 0; m_curcol = 0;
      m_exp = 0; m_lat = 0; m_kind = 0; m_acts = 0;
      m_pend = 0; m_valid = 0; m_done = 0; m_cpu = 0; m_we = 0;
    end else begin
      tick = (m_tcnt == REF - 1);
      m_tcnt = tick ? 0 : m_tcnt + 1;
      m_done = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0 && m_cpu) m_done = 1;
      end else if (m_pend) begin
        m_pend = 0; m_cpu = 0;
        m_left = (m_valid ? T_RP : 0) + T_RCD;
        m_valid = 0; m_rasrow = m_rptr; m_rptr = (m_rptr + 1) % 4; m_acts++;
      end else if (req) begin
        r = addr / 4; m_curcol = addr % 4; m_cpu = 1; m_we = we;
        if (m_valid && m_orow == r) begin m_kind = 0; lat = T_CL; end
        else if (m_valid) begin m_kind = 2; lat = T_RP + T_RCD + T_CL; m_acts++; end
        else begin m_kind = 1; lat = T_RCD + T_CL; m_acts++; end
        m_rasrow = r; m_valid = 1; m_orow = r;
        if (we) mem[addr] = wdata; else m_exp = mem[addr];
        m_left = lat; m_lat = lat;
      end
      if (tick) m_pend = 1;
    end
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", msg, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  int ras_rises = 0;
  logic ras_prev = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(busy == ((m_left > 0) || m_pend), "R8/R9 busy", busy, (m_left > 0) || m_pend);
      chk(done == m_done, "R6 done pulse", done, m_done);
      if (done && !m_we) chk(rdata == m_exp[7:0], "R2 read data", rdata, m_exp);
      chk(!(ras && cas), "R11 strobes exclusive", ras, 0);
      if (ras) chk(maddr == m_rasrow[1:0], "R10/R11 row on bus", maddr, m_rasrow);
      if (cas) chk(maddr == m_curcol[1:0], "R11 column on bus", maddr, m_curcol);
      if (ras && !ras_prev) ras_rises++;
    end
    ras_prev = ras;
  end

  task automatic access(input bit w, input int a, input int d, input bit inject);
    int n;
    while (busy) @(negedge clk);
    req = 1; we = w; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    req = 0; n = 0;
    if (inject) begin
      req = 1; we = 1; addr = 4'(a ^ 5); wdata = 8'hEE;
      @(negedge clk); n++;
      req = 0;
    end
    while (!done && n < 100) begin @(negedge clk); n++; end
    case (m_kind)
      0: chk(n == m_lat, "R3 open-row hit latency", n, T_CL);
      1: chk(n == m_lat && m_lat == T_RCD + T_CL, "R4 closed-row latency", n, T_RCD + T_CL);
      default: chk(n == m_lat && m_lat == T_RP + T_RCD + T_CL, "R5 row-switch latency",
                   n, T_RP + T_RCD + T_CL);
    endcase
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(0, "watchdog expired", cycles, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int acts0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !ras && !cas, "R1 reset outputs", {busy, done, ras, cas}, 0);
    access(0, 6, 0, 0);           // R1: unwritten reads 0 (model expects 0)
    chk(rdata == 8'h00, "R1 cleared cell", rdata, 0);
    // R2/R3/R7: run within row 1
    acts0 = m_acts;
    for (int c = 0; c < 4; c++) access(1, 4 + c, 8'h30 + c, 0);
    for (int c = 0; c < 4; c++) access(0, 4 + c, 0, 0);
    chk(m_acts - acts0 <= 1, "R7 single row opening for run", m_acts - acts0, 1);
    // R5: switch rows, earlier writes survive
    access(1, 13, 8'h5A, 0);
    access(0, 5, 0, 0);
    chk(rdata == 8'h31, "R5 writeback preserved", rdata, 8'h31);
    // R8: request during busy is dropped
    access(0, 13, 0, 1);
    access(0, 13 ^ 5, 0, 0);
    chk(rdata == 8'h00, "R8 injected write ignored", rdata, 0);
    // R9/R10: idle across several refreshes
    repeat (5 * REF) @(negedge clk);
    for (int a = 0; a < 16; a++) access(1, a, (a * 17) ^ 8'hA5, 0);
    repeat (3 * REF) @(negedge clk);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) access(0, r * 4 + c, 0, 0);
    for (int a = 15; a >= 0; a--) begin
      access(0, a, 0, 0);
      chk(rdata == 8'(((a * 17) ^ 8'hA5)), "R10 data kept through refresh", rdata,
          (a * 17) ^ 8'hA5);
    end
    repeat (4) @(negedge clk);
    // R7: every row opening produced one row-strobe rise
    chk(ras_rises == m_acts, "R7 row strobe count", ras_rises, m_acts);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule